// File: doc/BRIEF.md
# Microsequenced Word Move Engine

This block executes one word-sized move instruction per start request. It fetches the opcode word from a byte-addressed synchronous memory, decodes source and destination operand modes, fetches any displacement words that follow the opcode, and moves one 16-bit operand. The operand can come from or go to a data register, an address register, or memory. Every step is a single register transfer between a program counter, a memory address register, a memory buffer register and an instruction register, and each step has its own sequencer state.

The 32-bit register file is held inside the block. A host port loads and reads it, so a neighbouring arithmetic unit can keep a mirror of it. A start request carries the address of the instruction. The done output goes high once the program counter has advanced past the last word the instruction uses, and stays high until the next start.

Top module: `wmove_engine`

## Requirements
- R1: A start accepted while idle loads the program counter from `start_pc`. The program counter then advances by 2 for the opcode word and by 2 for each displacement word, so at done `pc_out` equals `start_pc` + 2, + 4 or + 6.
- R2: Read data is taken one cycle after `mem_rd`, with `mem_addr` held for that cycle. `mem_rd` and `mem_wr` are never high together, and one instruction drives `mem_wr` for at most one cycle.
- R3: The opcode word is decoded as follows. Bits [15:12] must be 0011. The destination register is in [11:9], the destination mode in [8:6], the source mode in [5:3] and the source register in [2:0]. Mode codes: 0 is data register, 1 is address register, 2 is memory at the address register, and 5 is memory at the address register plus a displacement.
- R4: A data register destination (mode 0) takes the moved word in its low 16 bits and keeps its upper 16 bits.
- R5: An address register source (mode 1) supplies its low word. An address register destination receives the word sign-extended to 32 bits.
- R6: Mode 2 uses the low 24 bits of the address register as the address. A store from a data register writes only that register's low word.
- R7: Mode 5 forms the address as the address register plus the 16-bit displacement sign-extended, taken modulo 2^24. A negative displacement lowers the address. The base register is never modified.
- R8: A word store presents the word with bits [15:8] destined for the byte at `mem_addr` and bits [7:0] for the byte at `mem_addr`+1.
- R9: When both operands use mode 5, the source displacement is the word at opcode+2 and the destination displacement is the word at opcode+4. When only one operand uses mode 5, its displacement is at opcode+2.
- R10: An opcode field other than 0011, or a mode other than 0, 1, 2 or 5, ends the instruction with `pc_out` = `start_pc`+2, no memory write and no register change.
- R11: `done` is low from the cycle after an accepted start until completion, then stays high until the next start. Host register loads made while an instruction runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start one instruction (taken when idle) |
| start_pc | input | 24 | Address of the opcode word |
| done | output | 1 | Instruction finished |
| pc_out | output | 24 | Program counter |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | 16 | Write word (high byte to `mem_addr`) |
| mem_rdata | input | 16 | Read word (high byte from `mem_addr`) |
| rf_we | input | 1 | Host register load |
| rf_wsel | input | 4 | Load select: bit 3 set selects an address register |
| rf_wdata | input | 32 | Load value |
| rf_rsel | input | 4 | Host read select, same coding as `rf_wsel` |
| rf_rdata | output | 32 | Selected register value |

## Verification
A wrong sequencer state shows at the ports within one instruction. It appears as a final `pc_out` off by one displacement word, as a stray or missing `mem_wr` pulse, or as a word stored at the wrong address. Swapped source and destination displacement fetches land the store several bytes away from where the requirement places it, so reading memory right after done exposes the error. Register-side mistakes, such as a lost upper half, a missing sign extension or a modified base register, show through the host read port as soon as done rises.

// File: rtl/wmove_pkg.sv
package wmove_pkg;

   typedef enum logic [4:0] {
      ST_IDLE, ST_F_MAR, ST_F_RD, ST_F_LAT, ST_F_IR, ST_F_INC, ST_DECODE,
      ST_OPER, ST_D_RD, ST_D_LAT, ST_D_INC, ST_EA,
      ST_M_RD, ST_M_LAT, ST_S_HOLD, ST_W_MBR, ST_WR
   } seq_state_t;

   localparam logic [3:0] OPC_MOVE_W = 4'b0011;
   localparam logic [2:0] MD_DREG    = 3'd0;
   localparam logic [2:0] MD_AREG    = 3'd1;
   localparam logic [2:0] MD_IND     = 3'd2;
   localparam logic [2:0] MD_DISP    = 3'd5;

   function automatic logic mode_ok(input logic [2:0] m);
      return (m == MD_DREG) || (m == MD_AREG) || (m == MD_IND) || (m == MD_DISP);
   endfunction

endpackage

// File: rtl/wmove_agen.sv
module wmove_agen #(
   parameter int ADDR_W = 24,
   parameter int WORD_W = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [WORD_W-1:0] disp,
   output logic [ADDR_W-1:0] ea
);
   logic [ADDR_W-1:0] disp_x;

   generate
      if (ADDR_W > WORD_W) begin : g_sext
         assign disp_x = {{(ADDR_W-WORD_W){disp[WORD_W-1]}}, disp};
      end else if (ADDR_W == WORD_W) begin : g_same
         assign disp_x = disp;
      end else begin : g_bad
         $error("wmove_agen: address narrower than displacement");
         assign disp_x = '0;
      end
   endgenerate

   assign ea = base + disp_x;
endmodule

// File: rtl/wmove_regfile.sv
module wmove_regfile #(
   parameter int NREG  = 8,
   parameter int REG_W = 32,
   localparam int SEL_W = 1 + $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             host_we,
   input  logic [SEL_W-1:0] host_wsel,
   input  logic [REG_W-1:0] host_wdata,
   input  logic [SEL_W-1:0] host_rsel,
   output logic [REG_W-1:0] host_rdata,
   input  logic             eng_we,
   input  logic [SEL_W-1:0] eng_sel,
   input  logic [REG_W-1:0] eng_wdata,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [REG_W-1:0] rd_val
);
   localparam int NTOT = 2 * NREG;

   logic [REG_W-1:0] q [NTOT];
   logic             host_ok;

   assign host_ok = host_we && !busy;

   generate
      for (genvar i = 0; i < NTOT; i++) begin : g_reg
         logic [REG_W-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               r <= '0;
            else if (eng_we && eng_sel == SEL_W'(i))
               r <= eng_wdata;
            else if (host_ok && host_wsel == SEL_W'(i))
               r <= host_wdata;
         end
         assign q[i] = r;
      end
   endgenerate

   assign host_rdata = q[host_rsel];
   assign rd_val     = q[rd_sel];

   assert_eng_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |-> busy);
endmodule

// File: rtl/wmove_seq.sv
module wmove_seq
   import wmove_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int WORD_W = 16,
   parameter int REG_W  = 32,
   parameter int NREG   = 8,
   localparam int SEL_W = 1 + $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_pc,
   output logic              done,
   output logic              busy,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [SEL_W-1:0]  rd_sel,
   input  logic [REG_W-1:0]  rd_val,
   output logic [WORD_W-1:0] disp,
   input  logic [ADDR_W-1:0] ea,
   output logic              eng_we,
   output logic [SEL_W-1:0]  eng_sel,
   output logic [REG_W-1:0]  eng_wdata
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

   seq_state_t        state;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [WORD_W-1:0] mbr_q, ir_q, opnd_q;
   logic              dst_ph, done_q;
   logic [2:0]        cur_mode, cur_reg;
   logic              take, legal;

   assign cur_mode = dst_ph ? ir_q[8:6]  : ir_q[5:3];
   assign cur_reg  = dst_ph ? ir_q[11:9] : ir_q[2:0];
   assign rd_sel   = {cur_mode != MD_DREG, cur_reg};
   assign take     = (state == ST_IDLE) && start;
   assign legal    = (ir_q[15:12] == OPC_MOVE_W) && mode_ok(ir_q[5:3]) && mode_ok(ir_q[8:6]);

   assign eng_we    = (state == ST_OPER) && dst_ph &&
                      (cur_mode == MD_DREG || cur_mode == MD_AREG);
   assign eng_sel   = rd_sel;
   assign eng_wdata = (cur_mode == MD_DREG) ? {rd_val[REG_W-1:WORD_W], opnd_q}
                                            : {{(REG_W-WORD_W){opnd_q[WORD_W-1]}}, opnd_q};

   assign mem_addr  = mar_q;
   assign mem_wdata = mbr_q;
   assign mem_rd    = (state == ST_F_RD) || (state == ST_D_RD) || (state == ST_M_RD);
   assign mem_wr    = (state == ST_WR);
   assign disp      = mbr_q;
   assign pc_out    = pc_q;
   assign done      = done_q;
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pc_q   <= '0;
         mar_q  <= '0;
         mbr_q  <= '0;
         ir_q   <= '0;
         opnd_q <= '0;
         dst_ph <= 1'b0;
         done_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               pc_q   <= start_pc;
               done_q <= 1'b0;
               state  <= ST_F_MAR;
            end
            ST_F_MAR: begin mar_q <= pc_q;      state <= ST_F_RD;  end
            ST_F_RD:  state <= ST_F_LAT;
            ST_F_LAT: begin mbr_q <= mem_rdata; state <= ST_F_IR;  end
            ST_F_IR:  begin ir_q  <= mbr_q;     state <= ST_F_INC; end
            ST_F_INC: begin pc_q  <= pc_q + STEP; state <= ST_DECODE; end
            ST_DECODE: begin
               dst_ph <= 1'b0;
               if (legal) state <= ST_OPER;
               else begin done_q <= 1'b1; state <= ST_IDLE; end
            end
            ST_OPER: begin
               if (!dst_ph) begin
                  case (cur_mode)
                     MD_IND:  begin mar_q <= rd_val[ADDR_W-1:0]; state <= ST_M_RD; end
                     MD_DISP: begin mar_q <= pc_q;               state <= ST_D_RD; end
                     default: begin opnd_q <= rd_val[WORD_W-1:0]; dst_ph <= 1'b1; end
                  endcase
               end else begin
                  case (cur_mode)
                     MD_IND:  begin mar_q <= rd_val[ADDR_W-1:0]; state <= ST_W_MBR; end
                     MD_DISP: begin mar_q <= pc_q;               state <= ST_D_RD;  end
                     default: begin done_q <= 1'b1;              state <= ST_IDLE;  end
                  endcase
               end
            end
            ST_D_RD:  state <= ST_D_LAT;
            ST_D_LAT: begin mbr_q <= mem_rdata; state <= ST_D_INC; end
            ST_D_INC: begin pc_q <= pc_q + STEP; state <= ST_EA; end
            ST_EA: begin
               mar_q <= ea;
               state <= dst_ph ? ST_W_MBR : ST_M_RD;
            end
            ST_M_RD:  state <= ST_M_LAT;
            ST_M_LAT: begin mbr_q <= mem_rdata; state <= ST_S_HOLD; end
            ST_S_HOLD: begin
               opnd_q <= mbr_q;
               dst_ph <= 1'b1;
               state  <= ST_OPER;
            end
            ST_W_MBR: begin mbr_q <= opnd_q; state <= ST_WR; end
            ST_WR: begin done_q <= 1'b1; state <= ST_IDLE; end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(take) && pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + STEP));

   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> $stable(mem_addr));

   assert_single_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_rd && !mem_wr && !eng_we));
endmodule

// File: rtl/wmove_engine.sv
module wmove_engine #(
   parameter int ADDR_W = 24,
   parameter int WORD_W = 16,
   parameter int REG_W  = 32,
   parameter int NREG   = 8,
   localparam int SEL_W = 1 + $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_pc,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              rf_we,
   input  logic [SEL_W-1:0]  rf_wsel,
   input  logic [REG_W-1:0]  rf_wdata,
   input  logic [SEL_W-1:0]  rf_rsel,
   output logic [REG_W-1:0]  rf_rdata
);
   generate
      if (WORD_W != 16) begin : g_chk_word
         $error("wmove_engine: opcode layout needs 16-bit words");
      end
      if (NREG != 8) begin : g_chk_nreg
         $error("wmove_engine: 3-bit register fields need 8 registers per bank");
      end
      if (REG_W <= WORD_W || REG_W < ADDR_W) begin : g_chk_reg
         $error("wmove_engine: register width too small");
      end
   endgenerate

   logic              busy, eng_we;
   logic [SEL_W-1:0]  rd_sel, eng_sel;
   logic [REG_W-1:0]  rd_val, eng_wdata;
   logic [WORD_W-1:0] disp;
   logic [ADDR_W-1:0] ea;

   wmove_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .REG_W(REG_W), .NREG(NREG)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
      .done(done), .busy(busy), .pc_out(pc_out),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rd_sel(rd_sel), .rd_val(rd_val), .disp(disp), .ea(ea),
      .eng_we(eng_we), .eng_sel(eng_sel), .eng_wdata(eng_wdata)
   );

   wmove_agen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) agen_i (
      .base(rd_val[ADDR_W-1:0]), .disp(disp), .ea(ea)
   );

   wmove_regfile #(.NREG(NREG), .REG_W(REG_W)) rf_i (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .host_we(rf_we), .host_wsel(rf_wsel), .host_wdata(rf_wdata),
      .host_rsel(rf_rsel), .host_rdata(rf_rdata),
      .eng_we(eng_we), .eng_sel(eng_sel), .eng_wdata(eng_wdata),
      .rd_sel(rd_sel), .rd_val(rd_val)
   );
endmodule

// File: tb/wmove_engine_tb.sv
module wmove_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [23:0] PROG = 24'h000C00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] start_pc = '0;
   logic        done;
   logic [23:0] pc_out, mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        rf_we = 1'b0;
   logic [3:0]  rf_wsel = '0, rf_rsel = '0;
   logic [31:0] rf_wdata = '0, rf_rdata;

   logic [7:0]  mem [4096];
   int          wr_cnt = 0;
   int          checks = 0, errors = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wmove_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
      .done(done), .pc_out(pc_out), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
      .rf_rsel(rf_rsel), .rf_rdata(rf_rdata)
   );

   // memory model: big-endian bytes, read data one cycle after strobe (R2, R8)
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= {mem[mem_addr[11:0]], mem[mem_addr[11:0] + 12'd1]};
      if (mem_wr) begin
         mem[mem_addr[11:0]]         <= mem_wdata[15:8];
         mem[mem_addr[11:0] + 12'd1] <= mem_wdata[7:0];
         wr_cnt <= wr_cnt + 1;
      end
   end

   typedef struct packed {
      logic [15:0] op;
      logic [15:0] x1;
      logic [15:0] x2;
      logic        k_mem;
      logic [11:0] idx;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{16'h3401, 16'h0000, 16'h0000, 1'b0, 12'd2,   32'hCA02_1211}, // R4 R3 d1->d2
      '{16'h3A0B, 16'h0000, 16'h0000, 1'b0, 12'd5,   32'hCA05_0500}, // R5 a3->d5
      '{16'h3846, 16'h0000, 16'h0000, 1'b0, 12'd12,  32'h0000_1766}, // R5 d6->a4
      '{16'h3451, 16'h0000, 16'h0000, 1'b0, 12'd10,  32'hFFFF_A5A4}, // R5 R6 (a1)->a2 sign-ext
      '{16'h3010, 16'h0000, 16'h0000, 1'b0, 12'd0,   32'hCA00_A5A4}, // R6 R4 (a0)->d0
      '{16'h3683, 16'h0000, 16'h0000, 1'b1, 12'h500, 32'h0000_1433}, // R6 d3->(a3) low 24 bits
      '{16'h3143, 16'h0002, 16'h0000, 1'b1, 12'h202, 32'h0000_1433}, // R7 d3->2(a0)
      '{16'h3143, 16'hFFFC, 16'h0000, 1'b1, 12'h1FC, 32'h0000_1433}, // R7 negative disp
      '{16'h3143, 16'hFFFC, 16'h0000, 1'b0, 12'd8,   32'h0000_0200}, // R7 base kept
      '{16'h362A, 16'h0004, 16'h0000, 1'b0, 12'd3,   32'hCA03_A1A0}, // R7 4(a2)->d3
      '{16'h3368, 16'h00A4, 16'h0006, 1'b1, 12'h306, 32'h0000_0100}, // R9 mem to mem
      '{16'h3F56, 16'hFFF8, 16'h0000, 1'b1, 12'h8F8, 32'h0000_A5A4}, // R9 R7 (a6)->-8(a7)
      '{16'h4E71, 16'h0000, 16'h0000, 1'b0, 12'd0,   32'hCA00_1100}, // R10 foreign opcode
      '{16'h3018, 16'h0000, 16'h0000, 1'b0, 12'd0,   32'hCA00_1100}  // R10 bad mode 3
   };

   function automatic logic mode_legal(input logic [2:0] m);
      return m == 3'd0 || m == 3'd1 || m == 3'd2 || m == 3'd5;
   endfunction

   function automatic logic op_legal(input logic [15:0] op);
      return op[15:12] == 4'b0011 && mode_legal(op[8:6]) && mode_legal(op[5:3]);
   endfunction

   function automatic int pc_delta(input logic [15:0] op);
      if (!op_legal(op)) return 2;
      return 2 + ((op[5:3] == 3'd5) ? 2 : 0) + ((op[8:6] == 3'd5) ? 2 : 0);
   endfunction

   function automatic int exp_writes(input logic [15:0] op);
      return (op_legal(op) && (op[8:6] == 3'd2 || op[8:6] == 3'd5)) ? 1 : 0;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_reg(input logic [3:0] sel, input logic [31:0] val);
      @(negedge clk);
      rf_we = 1'b1; rf_wsel = sel; rf_wdata = val;
      @(negedge clk);
      rf_we = 1'b0;
   endtask

   task automatic read_reg(input logic [3:0] sel, output logic [31:0] val);
      rf_rsel = sel;
      #1 val = rf_rdata;
   endtask

   task automatic init_all();
      for (int a = 0; a < 4096; a++) mem[a] = 8'(a) ^ 8'hA5;
      for (int i = 0; i < 8; i++) begin
         load_reg(4'(i), {16'hCA00 + 16'(i), 16'h1100 + 16'(i) * 16'h0111});
         load_reg(4'(8 + i), (i == 3) ? 32'hFF00_0500 : 32'h200 + 32'(i) * 32'h100);
      end
   endtask

   task automatic launch(input logic [15:0] op, input logic [15:0] x1, input logic [15:0] x2);
      mem[PROG[11:0]]     = op[15:8]; mem[PROG[11:0] + 1] = op[7:0];
      mem[PROG[11:0] + 2] = x1[15:8]; mem[PROG[11:0] + 3] = x1[7:0];
      mem[PROG[11:0] + 4] = x2[15:8]; mem[PROG[11:0] + 5] = x2[7:0];
      wr_cnt = 0;
      @(negedge clk);
      start = 1'b1; start_pc = PROG;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int n = 0; n < 200; n++) begin
         if (done) return;
         @(negedge clk);
      end
      check(1'b0, "R11 timeout", {31'd0, done}, 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // reset state: R11 R2 R1
      check(done == 1'b0, "R11 reset done", {31'd0, done}, 32'd0);
      check(!mem_rd && !mem_wr, "R2 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
      check(pc_out == 24'd0, "R1 reset pc", {8'd0, pc_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         init_all();
         launch(TBL[k].op, TBL[k].x1, TBL[k].x2);
         wait_done();
         check(pc_out == PROG + 24'(pc_delta(TBL[k].op)), "R1 R9 pc at done",
               {8'd0, pc_out}, {8'd0, PROG + 24'(pc_delta(TBL[k].op))});
         check(wr_cnt == exp_writes(TBL[k].op), "R2 R10 write count",
               32'(wr_cnt), 32'(exp_writes(TBL[k].op)));
         if (TBL[k].k_mem) begin
            v = {16'd0, mem[TBL[k].idx], mem[TBL[k].idx + 12'd1]};
            check(v == TBL[k].exp, "R6 R7 R9 stored word", v, TBL[k].exp);
         end else begin
            read_reg(TBL[k].idx[3:0], v);
            check(v == TBL[k].exp, "R4 R5 R7 R10 register", v, TBL[k].exp);
         end
      end

      // R8: byte order of a store of d3 (low word 1433) to (a3) -> 0x500
      init_all();
      launch(16'h3683, 16'h0, 16'h0);
      wait_done();
      check(mem[12'h500] == 8'h14, "R8 high byte at EA", {24'd0, mem[12'h500]}, 32'h14);
      check(mem[12'h501] == 8'h33, "R8 low byte at EA+1", {24'd0, mem[12'h501]}, 32'h33);

      // R11: done low while running, host loads ignored while busy, done held after
      init_all();
      launch(16'h3401, 16'h0, 16'h0);
      check(done == 1'b0, "R11 done low after start", {31'd0, done}, 32'd0);
      rf_we = 1'b1; rf_wsel = 4'd7; rf_wdata = 32'h0;
      @(negedge clk);
      rf_we = 1'b0;
      wait_done();
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R11 done held", {31'd0, done}, 32'd1);
      read_reg(4'd7, v);
      check(v == 32'hCA07_1877, "R11 busy load ignored", v, 32'hCA07_1877);
      read_reg(4'd1, v);
      check(v == 32'hCA01_1211, "R4 source unchanged", v, 32'hCA01_1211);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule